// File: doc/BRIEF.md
# Redundant Store Release Checker

This block guards the memory side of a pair of redundant threads that run the same program. Each thread sends its stores (address, data and byte mask) into its own queue. Stores leave the block only after a cross-thread check. The block compares the oldest entry of the leading queue with the oldest entry of the trailing queue on every cycle. When all fields agree, it issues exactly one cache write and retires both entries. A fault in either copy of the program is therefore caught before any value leaves the protected region.

On any disagreement, the block raises a recovery request. It then freezes: no cache write, no pop and no accepted push. This lasts until an external flush clears both queues. Each queue reports full and not-empty. The trailing queue holds back its last slot while the leading queue is empty, so the trailing store that matches the oldest leading store can always be accepted. This prevents deadlock.

Top module: `stq_checker`

## Requirements
- R1: After reset, both queues are empty: `lead_nempty`, `trail_nempty`, `lead_full`, `trail_full`, `wr_en` and `recover` are all 0.
- R2: A cache write happens only after both queue heads are present and equal in address, mask and checked data. `wr_en` is high for exactly one cycle, in the cycle after the heads agree. `wr_addr`, `wr_data` and `wr_mask` carry the leading store, and both heads are then removed.
- R3: Stores are released in the order the threads pushed them. The first pushed pair is written first.
- R4: A leading store with no trailing partner yet stays queued indefinitely and causes no write.
- R5: When the heads differ in address, mask or a checked data byte, `recover` rises in the next cycle and no write is issued for that pair.
- R6: While `recover` is 1, pushes from either thread are ignored and no write occurs. Both queues keep their contents.
- R7: A flush empties both queues and clears `recover` in the following cycle. A flush has priority over pushes in the same cycle.
- R8: `lead_full` is 1 when the leading queue holds DEPTH entries. A leading push while full is dropped.
- R9: While the leading queue is empty, `trail_full` rises once the trailing queue holds DEPTH-1 entries, keeping one slot in reserve. Once the leading queue is non-empty, that reserve slot becomes available.
- R10: With MASK_DATA_CMP set (the default), data bytes whose mask bit (bit i covers data bits 8i+7..8i) is 0 do not take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears both queues and the recovery flag |
| lead_push | input | 1 | Leading thread store valid |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| lead_mask | input | DATA_W/8 | Leading store byte enables |
| lead_full | output | 1 | Leading queue cannot accept a store |
| lead_nempty | output | 1 | Leading queue holds at least one store |
| trail_push | input | 1 | Trailing thread store valid |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| trail_mask | input | DATA_W/8 | Trailing store byte enables |
| trail_full | output | 1 | Trailing queue cannot accept a store |
| trail_nempty | output | 1 | Trailing queue holds at least one store |
| wr_en | output | 1 | Cache write strobe |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| wr_mask | output | DATA_W/8 | Cache write byte enables |
| recover | output | 1 | Mismatch detected, recovery requested |

## Verification
A corrupted queue pointer or count shows up as a write of the wrong store, or of a store that was pushed and dropped. The bench detects this at the first write after the fault, because it checks every write address against the push order. A stuck or lost recovery flag is exposed within one cycle of the mismatching pair: either a write appears or `recover` stays low. A wrong reserve rule is visible directly on `trail_full` after the DEPTH-1th trailing push. Dropped-push faults surface when the queue is drained, through the not-empty flags.

// File: rtl/stq_pkg.sv
package stq_pkg;
   typedef enum logic [1:0] {
      CMP_IDLE  = 2'd0,
      CMP_MATCH = 2'd1,
      CMP_MISS  = 2'd2
   } cmp_res_e;
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("stq_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wptr] <= din;
   end

   assign dout = mem[rptr];

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);
   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> count != '0);
endmodule

// File: rtl/stq_cmp.sv
module stq_cmp
   import stq_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 64,
   parameter bit MASK_DATA_CMP = 1'b1,
   localparam int MW           = DATA_W / 8
) (
   input  logic              lead_v,
   input  logic              trail_v,
   input  logic [ADDR_W-1:0] lead_addr,
   input  logic [DATA_W-1:0] lead_data,
   input  logic [MW-1:0]     lead_mask,
   input  logic [ADDR_W-1:0] trail_addr,
   input  logic [DATA_W-1:0] trail_data,
   input  logic [MW-1:0]     trail_mask,
   output cmp_res_e          res
);
   logic data_eq;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("stq_cmp: DATA_W must be a non-zero multiple of 8");
      end
      if (MASK_DATA_CMP) begin : g_masked
         always_comb begin
            data_eq = 1'b1;
            for (int b = 0; b < MW; b++) begin
               if (lead_mask[b] && (lead_data[b*8 +: 8] != trail_data[b*8 +: 8]))
                  data_eq = 1'b0;
            end
         end
      end else begin : g_full
         assign data_eq = (lead_data == trail_data);
      end
   endgenerate

   always_comb begin
      if (!(lead_v && trail_v))
         res = CMP_IDLE;
      else if (lead_addr == trail_addr && lead_mask == trail_mask && data_eq)
         res = CMP_MATCH;
      else
         res = CMP_MISS;
   end
endmodule

// File: rtl/stq_checker.sv
module stq_checker
   import stq_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 64,
   parameter int DEPTH         = 8,
   parameter bit MASK_DATA_CMP = 1'b1,
   localparam int MW           = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lead_push,
   input  logic [ADDR_W-1:0] lead_addr,
   input  logic [DATA_W-1:0] lead_data,
   input  logic [MW-1:0]     lead_mask,
   output logic              lead_full,
   output logic              lead_nempty,
   input  logic              trail_push,
   input  logic [ADDR_W-1:0] trail_addr,
   input  logic [DATA_W-1:0] trail_data,
   input  logic [MW-1:0]     trail_mask,
   output logic              trail_full,
   output logic              trail_nempty,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [MW-1:0]     wr_mask,
   output logic              recover
);
   localparam int EW = ADDR_W + DATA_W + MW;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_C   = CW'(DEPTH);
   localparam logic [CW-1:0] RESERVE_C = CW'(DEPTH - 1);

   logic [EW-1:0] lead_head, trail_head;
   logic [CW-1:0] lead_cnt, trail_cnt;
   logic          lead_acc, trail_acc, pop, recover_q;
   cmp_res_e      cmp_res;

   assign lead_nempty  = (lead_cnt != '0);
   assign trail_nempty = (trail_cnt != '0);
   assign lead_full    = (lead_cnt == DEPTH_C);
   assign trail_full   = (trail_cnt == DEPTH_C) ||
                         (trail_cnt == RESERVE_C && !lead_nempty);

   assign lead_acc  = lead_push  && !lead_full  && !recover_q && !flush;
   assign trail_acc = trail_push && !trail_full && !recover_q && !flush;
   assign pop       = (cmp_res == CMP_MATCH) && !recover_q && !flush;

   stq_fifo #(.W(EW), .DEPTH(DEPTH)) u_lead_q (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(lead_acc),
      .din({lead_addr, lead_data, lead_mask}), .pop(pop),
      .dout(lead_head), .count(lead_cnt)
   );

   stq_fifo #(.W(EW), .DEPTH(DEPTH)) u_trail_q (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(trail_acc),
      .din({trail_addr, trail_data, trail_mask}), .pop(pop),
      .dout(trail_head), .count(trail_cnt)
   );

   stq_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_DATA_CMP(MASK_DATA_CMP)) u_cmp (
      .lead_v(lead_nempty), .trail_v(trail_nempty),
      .lead_addr(lead_head[EW-1 -: ADDR_W]),
      .lead_data(lead_head[MW +: DATA_W]),
      .lead_mask(lead_head[MW-1:0]),
      .trail_addr(trail_head[EW-1 -: ADDR_W]),
      .trail_data(trail_head[MW +: DATA_W]),
      .trail_mask(trail_head[MW-1:0]),
      .res(cmp_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recover_q <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_mask   <= '0;
      end else begin
         if (flush)
            recover_q <= 1'b0;
         else if (cmp_res == CMP_MISS)
            recover_q <= 1'b1;
         wr_en <= pop;
         if (pop) begin
            wr_addr <= lead_head[EW-1 -: ADDR_W];
            wr_data <= lead_head[MW +: DATA_W];
            wr_mask <= lead_head[MW-1:0];
         end
      end
   end

   assign recover = recover_q;

   // R2
   write_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(lead_nempty && trail_nempty));
   // R5
   no_write_in_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recover_q |-> !wr_en);
   // R6
   frozen_in_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (recover_q && !flush) |=> ($stable(lead_cnt) && $stable(trail_cnt)));
   // R7
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!recover_q && lead_cnt == '0 && trail_cnt == '0));
   // R9
   reserve_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_nempty && !recover_q) |-> trail_cnt < DEPTH_C);
endmodule

// File: tb/tb_stq_checker.sv
`timescale 1ns/1ps
module tb_stq_checker;
   localparam int AW = 16, DW = 32, DEP = 4, MW = DW / 8;

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
   logic lp = 1'b0, tp = 1'b0;
   logic [AW-1:0] la = '0, ta = '0, wr_addr;
   logic [DW-1:0] ld = '0, td = '0, wr_data;
   logic [MW-1:0] lm = '0, tm = '0, wr_mask;
   logic lead_full, lead_nempty, trail_full, trail_nempty, wr_en, recover;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   stq_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lead_push(lp), .lead_addr(la), .lead_data(ld), .lead_mask(lm),
      .lead_full(lead_full), .lead_nempty(lead_nempty),
      .trail_push(tp), .trail_addr(ta), .trail_data(td), .trail_mask(tm),
      .trail_full(trail_full), .trail_nempty(trail_nempty),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .recover(recover)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      lp = 1'b0; tp = 1'b0; flush = 1'b0;
   endtask

   task automatic lead(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
      lp = 1'b1; la = a; ld = d; lm = m; step();
   endtask

   task automatic trail(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
      tp = 1'b1; ta = a; td = d; tm = m; step();
   endtask

   task automatic do_flush();
      flush = 1'b1; step();
   endtask

   task automatic t_reset();
      chk("R1", "lead_nempty", 64'(lead_nempty), 0);
      chk("R1", "trail_nempty", 64'(trail_nempty), 0);
      chk("R1", "full flags", 64'({lead_full, trail_full}), 0);
      chk("R1", "wr_en/recover", 64'({wr_en, recover}), 0);
   endtask

   task automatic t_match();
      lead(16'h0100, 32'hDEAD_BEEF, 4'hF);
      trail(16'h0100, 32'hDEAD_BEEF, 4'hF);
      chk("R2", "no write before compare", 64'(wr_en), 0);
      step();
      chk("R2", "wr_en", 64'(wr_en), 1);
      chk("R2", "wr fields", {wr_addr, wr_data, wr_mask, 12'h0}, {16'h0100, 32'hDEAD_BEEF, 4'hF, 12'h0});
      step();
      chk("R2", "single write", 64'(wr_en), 0);
      chk("R2", "queues drained", 64'({lead_nempty, trail_nempty}), 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 3; i++) lead(AW'(16'h0200 + i), DW'(32'h1000 + i), 4'hF);
      step();
      chk("R4", "lead waits without partner", 64'(wr_en), 0);
      chk("R4", "lead still queued", 64'(lead_nempty), 1);
      for (int i = 0; i < 3; i++) begin
         trail(AW'(16'h0200 + i), DW'(32'h1000 + i), 4'hF);
         if (i > 0) chk("R3", "order addr", {wr_en, wr_addr}, {1'b1, AW'(16'h0200 + i - 1)});
      end
      step();
      chk("R3", "last in order", {wr_en, wr_addr}, {1'b1, 16'h0202});
      step();
      chk("R3", "drained", 64'({wr_en, lead_nempty, trail_nempty}), 0);
   endtask

   task automatic t_mismatch(input string what, input logic [AW-1:0] ta2,
                             input logic [DW-1:0] td2, input logic [MW-1:0] tm2);
      lead(16'h0300, 32'h0000_1234, 4'hF);
      trail(ta2, td2, tm2);
      step();
      chk("R5", {what, " recover"}, 64'({recover, wr_en}), 64'b10);
      lead(16'h0301, 32'h5, 4'hF);
      trail(16'h0301, 32'h5, 4'hF);
      step();
      chk("R6", {what, " frozen"}, 64'({recover, wr_en, lead_nempty, trail_nempty}), 64'b1011);
      do_flush();
      chk("R7", {what, " flush"}, 64'({recover, lead_nempty, trail_nempty}), 0);
   endtask

   task automatic t_masked();
      lead(16'h0400, 32'hAAAA_1234, 4'b0011);
      trail(16'h0400, 32'h5555_1234, 4'b0011);
      step();
      chk("R10", "masked bytes ignored", {wr_en, recover, wr_data}, {2'b10, 32'hAAAA_1234});
      chk("R10", "wr_mask", 64'(wr_mask), 64'b0011);
      step();
   endtask

   task automatic t_full();
      for (int i = 0; i < DEP; i++) begin
         chk("R8", "not full yet", 64'(lead_full), 0);
         lead(AW'(16'h0500 + i), DW'(i), 4'hF);
      end
      chk("R8", "lead_full", 64'(lead_full), 1);
      lead(16'h0504, 32'h4, 4'hF);
      for (int i = 0; i < DEP; i++) begin
         trail(AW'(16'h0500 + i), DW'(i), 4'hF);
         if (i > 0) chk("R8", "drain order", {wr_en, wr_addr}, {1'b1, AW'(16'h0500 + i - 1)});
      end
      trail(16'h0504, 32'h4, 4'hF);
      chk("R8", "last stored", {wr_en, wr_addr}, {1'b1, 16'h0503});
      step();
      chk("R8", "push while full dropped", 64'({wr_en, lead_nempty, trail_nempty}), 64'b001);
      do_flush();
   endtask

   task automatic t_reserve();
      for (int i = 0; i < DEP - 1; i++) begin
         chk("R9", "trail_full early", 64'(trail_full), 0);
         trail(AW'(16'h0600 + i), DW'(i), 4'hF);
      end
      chk("R9", "reserve held", 64'(trail_full), 1);
      lead(16'h0600, 32'h0, 4'hF);
      chk("R9", "reserve released", 64'({trail_full, wr_en}), 0);
      step();
      chk("R9", "partner write", {wr_en, wr_addr}, {1'b1, 16'h0600});
      do_flush();
   endtask

   task automatic t_flush_priority();
      flush = 1'b1; lp = 1'b1; la = 16'h0700; ld = 32'h7; lm = 4'hF;
      step();
      chk("R7", "flush beats push", 64'(lead_nempty), 0);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_match();
      t_order();
      t_mismatch("addr", 16'h0301, 32'h0000_1234, 4'hF);
      t_mismatch("data", 16'h0300, 32'h0000_1235, 4'hF);
      t_mismatch("mask", 16'h0300, 32'h0000_1234, 4'h7);
      t_masked();
      t_full();
      t_reserve();
      t_flush_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule